// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block sits between a simple host I/O bus (16-bit address, 8-bit data, single-cycle read and write strobes) and the configuration registers of an I/O-mapped peripheral controller. It hides those registers behind a lock. After reset the block is in Run mode. The only bus cycle it responds to is an unlock key byte written to its base port. Once unlocked, the base port becomes an index port and the next address up becomes a data port, and together they give access to a small register file. A lock key written to the base port returns the block to Run mode.

The base port address is chosen by a strap input that is sampled while reset is asserted. Software can later move it through a pair of address registers in the register file. The same register file holds one enable bit for each logical device, and these bits drive the `dev_en` outputs. The host bus logic uses the `io_hit` output to tell which accesses the block has claimed and when `io_rdata` carries valid read data.

Top module: `cfg_port_dec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the block is in Run mode, every `dev_en` bit is 0, and the stored index is 0x00.
- R2: The base port is 0x002E when `strap` is low during reset, and 0x004E when `strap` is high.
- R3: In Run mode, writing 0x55 to the base port is claimed and puts the block into Configuration mode from the next cycle.
- R4: In Configuration mode, writing 0xAA to the base port is claimed, returns the block to Run mode from the next cycle, and leaves the stored index unchanged.
- R5: In Run mode, every other access is unclaimed: reads of any address, any access to base+1, and base-port writes of values other than 0x55. An unclaimed access leaves `io_hit` low, drives `io_rdata` to 0x00, and changes no state.
- R6: In Configuration mode, writing any value except 0xAA to the base port stores it as the index. Reading the base port returns the stored index.
- R7: The device enables sit at indices 0x30 and up. Bit k of `dev_en` is bit k mod 8 of the register at index 0x30 + k/8. Data-port writes update these registers, and data-port reads return them, with the bits at or above NDEV (12 by default) reading 0.
- R8: After reset, index 0x26 reads the low byte of the base address and index 0x27 reads the high byte. A write to 0x26 alone does not move the port. A write to 0x27 moves the base to {0x27 value, 0x26 value} from the next cycle, and the old address is then no longer decoded.
- R9: A data-port read of an unimplemented index returns 0xFF. A data-port write to an unimplemented index changes nothing that can be observed.
- R10: `io_hit` is high in the same cycle as each claimed access and at no other time. `io_rdata` is valid in that cycle for a claimed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap | input | 1 | Selects the base address at reset |
| io_addr | input | 16 | Bus address |
| io_wdata | input | 8 | Bus write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while `io_hit` and `io_rd` are both high |
| io_hit | output | 1 | The current access is claimed |
| dev_en | output | NDEV | Logical-device enables |

## Verification
The assertions assume three things about the bus. `io_wr` and `io_rd` are never high in the same cycle. Each strobe lasts a single cycle. `strap` holds steady for the whole time reset is asserted. The bench drives at most one strobe per access and drops it after one clock edge. It changes `strap` only while reset is low, and it keeps the strap value unchanged until reset is released. The random traffic is weighted toward the live base port and the port above it, so that both keys, index writes and relocations occur often. A shadow model tracks the base address, so that stimulus keeps hitting the port after each move.

// File: rtl/cfg_port_dec.sv
module cfg_port_dec #(
  parameter int          NDEV     = 12,
  parameter logic [15:0] ADDR_LO  = 16'h002E,
  parameter logic [15:0] ADDR_HI  = 16'h004E,
  parameter logic [7:0]  KEY_ON   = 8'h55,
  parameter logic [7:0]  KEY_OFF  = 8'hAA,
  parameter logic [7:0]  IDX_BLO  = 8'h26,
  parameter logic [7:0]  IDX_BHI  = 8'h27,
  parameter logic [7:0]  IDX_EN   = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap,
  input  logic [15:0]     io_addr,
  input  logic [7:0]      io_wdata,
  input  logic            io_wr,
  input  logic            io_rd,
  output logic [7:0]      io_rdata,
  output logic            io_hit,
  output logic [NDEV-1:0] dev_en
);
  localparam int NEN = (NDEV + 7) / 8;

  logic            cfg_mode;
  logic [15:0]     base;
  logic [7:0]      lo_pend;
  logic [7:0]      idx;
  logic [NDEV-1:0] en_q;
  logic [8*NEN-1:0] en_pad;
  logic [7:0]      reg_rd;

  wire at_idx  = io_addr == base;
  wire at_dat  = io_addr == base + 16'd1;
  wire key_on  = !cfg_mode && io_wr && at_idx && io_wdata == KEY_ON;
  wire cfg_acc = cfg_mode && (io_wr || io_rd) && (at_idx || at_dat);
  wire idx_wr  = cfg_mode && io_wr && at_idx;
  wire key_off = idx_wr && io_wdata == KEY_OFF;
  wire dat_wr  = cfg_mode && io_wr && at_dat;

  assign io_hit   = key_on || cfg_acc;
  assign io_rdata = (io_rd && io_hit) ? (at_idx ? idx : reg_rd) : 8'h00;
  assign dev_en   = en_q;

  always_comb begin
    en_pad = '0;
    en_pad[NDEV-1:0] = en_q;
  end

  always_comb begin
    reg_rd = 8'hFF;
    if (idx == IDX_BLO) reg_rd = lo_pend;
    if (idx == IDX_BHI) reg_rd = base[15:8];
    for (int k = 0; k < NEN; k++)
      if (idx == 8'(int'(IDX_EN) + k)) reg_rd = en_pad[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      idx      <= 8'h00;
      en_q     <= '0;
      base     <= strap ? ADDR_HI : ADDR_LO;
      lo_pend  <= strap ? ADDR_HI[7:0] : ADDR_LO[7:0];
    end else begin
      if (key_on) cfg_mode <= 1'b1;
      if (key_off) cfg_mode <= 1'b0;
      else if (idx_wr) idx <= io_wdata;
      if (dat_wr) begin
        if (idx == IDX_BLO) lo_pend <= io_wdata;
        if (idx == IDX_BHI) base <= {io_wdata, lo_pend};
        for (int i = 0; i < NDEV; i++)
          if (idx == 8'(int'(IDX_EN) + i / 8)) en_q[i] <= io_wdata[i % 8];
      end
    end
  end
endmodule

module cfg_port_dec_chk #(
  parameter int NDEV = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     io_addr,
  input logic [7:0]      io_wdata,
  input logic            io_wr,
  input logic            io_rd,
  input logic            io_hit,
  input logic [NDEV-1:0] dev_en,
  input logic            cfg_mode,
  input logic [15:0]     base,
  input logic [7:0]      idx
);
  assert_reset_run_R1: assert property (@(posedge clk)
    !rst_n |=> (!cfg_mode && dev_en == '0 && idx == 8'h00));

  assert_key_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && io_wr && io_addr == base && io_wdata == 8'h55) |=> cfg_mode);

  assert_key_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && io_wr && io_addr == base && io_wdata == 8'hAA) |=> (!cfg_mode && $stable(idx)));

  assert_run_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && io_rd) |-> !io_hit);

  assert_run_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !(io_wr && io_addr == base && io_wdata == 8'h55)) |=> (!cfg_mode && $stable(base) && $stable(dev_en)));

  assert_index_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && io_wr && io_addr == base && io_wdata != 8'hAA) |=> idx == $past(io_wdata));

  assert_relocate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && io_wr && io_addr == base + 16'd1 && idx == 8'h27) |=> base[15:8] == $past(io_wdata));

  assert_hit_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_wr || io_rd));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_rd));
endmodule

bind cfg_port_dec cfg_port_dec_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_hit(io_hit), .dev_en(dev_en),
  .cfg_mode(cfg_mode), .base(base), .idx(idx)
);

// File: tb/sim_cfg_port_dec.sv
module sim_cfg_port_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_hit;
  logic [11:0] dev_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit          m_cfg;
  logic [15:0] m_base;
  logic [7:0]  m_lo;
  logic [7:0]  m_idx;
  logic [11:0] m_en;

  always #2 clk = ~clk;

  cfg_port_dec u0 (
    .clk(clk), .rst_n(rst_n), .strap(strap), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_hit(io_hit), .dev_en(dev_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] e_reg(input logic [7:0] i);
    case (i)
      8'h26: return m_lo;
      8'h27: return m_base[15:8];
      8'h30: return m_en[7:0];
      8'h31: return {4'h0, m_en[11:8]};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit e_hit(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d);
    if (!m_cfg) return w && a == m_base && d == 8'h55;
    return (w || r) && (a == m_base || a == m_base + 16'd1);
  endfunction

  function automatic logic [7:0] e_rdata(input logic [15:0] a, input bit r, input bit h);
    if (!(r && h)) return 8'h00;
    if (a == m_base) return m_idx;
    return e_reg(m_idx);
  endfunction

  task automatic m_reset(input bit s);
    m_cfg = 0; m_idx = 8'h00; m_en = '0;
    m_base = s ? 16'h004E : 16'h002E;
    m_lo = m_base[7:0];
  endtask

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    if (!m_cfg) begin
      if (a == m_base && d == 8'h55) m_cfg = 1;
    end else if (a == m_base) begin
      if (d == 8'hAA) m_cfg = 0; else m_idx = d;
    end else if (a == m_base + 16'd1) begin
      case (m_idx)
        8'h26: m_lo = d;
        8'h27: m_base = {d, m_lo};
        8'h30: m_en[7:0] = d;
        8'h31: m_en[11:8] = d[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic acc(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d, input string tag);
    bit eh;
    logic [7:0] er;
    @(negedge clk);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    eh = e_hit(a, w, r, d);
    er = e_rdata(a, r, eh);
    chk(io_hit === eh, {tag, " hit R10"}, int'(io_hit), int'(eh));
    if (r) chk(io_rdata === er, {tag, " rdata"}, int'(io_rdata), int'(er));
    @(posedge clk);
    #1;
    io_wr = 0; io_rd = 0;
    if (w) m_write(a, d);
    chk(dev_en === m_en, {tag, " dev_en"}, int'(dev_en), int'(m_en));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    acc(a, 1, 0, d, tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    acc(a, 0, 1, 8'h00, tag);
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 0; strap = s; io_wr = 0; io_rd = 0;
    repeat (3) @(negedge clk);
    m_reset(s);
    chk(dev_en === 12'h000, "R1 dev_en in reset", int'(dev_en), 0);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    m_reset(0);
    do_reset(0);

    rd(16'h002E, "R5 run read base");
    rd(16'h002F, "R5 run read data port");
    wr(16'h002E, 8'h12, "R5 run non-key write");
    wr(16'h002F, 8'h55, "R5 run data write");
    wr(16'h004E, 8'h55, "R2 key at other strap base");
    rd(16'h002E, "R5 still run");
    wr(16'h002E, 8'h55, "R3 unlock");
    rd(16'h002E, "R1 index reset value");
    wr(16'h002E, 8'h30, "R6 index write");
    wr(16'h002F, 8'hA5, "R7 enable low byte");
    rd(16'h002F, "R7 enable low readback");
    wr(16'h002E, 8'h31, "R6 index 31");
    wr(16'h002F, 8'hFF, "R7 enable high byte");
    rd(16'h002F, "R7 upper bits read zero");
    wr(16'h002E, 8'h55, "R6 key-on value stored as index");
    rd(16'h002E, "R6 index readback 55");
    wr(16'h002E, 8'h10, "R9 index unimplemented");
    rd(16'h002F, "R9 reads FF");
    wr(16'h002F, 8'h33, "R9 write ignored");
    rd(16'h002F, "R9 still FF");
    wr(16'h002E, 8'h26, "R8 index 26");
    rd(16'h002F, "R8 low byte after reset");
    wr(16'h002F, 8'h80, "R8 low byte pending");
    rd(16'h002E, "R8 old base still live");
    wr(16'h002E, 8'h27, "R8 index 27");
    rd(16'h002F, "R8 high byte after reset");
    wr(16'h002F, 8'h03, "R8 relocate");
    rd(16'h002E, "R8 old base dropped");
    rd(16'h0380, "R8 new base index read");
    rd(16'h0381, "R8 new high byte");
    wr(16'h0380, 8'hAA, "R4 lock");
    rd(16'h0380, "R4 run after lock");
    wr(16'h0380, 8'h55, "R3 unlock at new base");
    rd(16'h0380, "R4 index kept through lock");

    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] a;
      logic [7:0] d;
      bit w;
      sel = int'($urandom % 10);
      w = ($urandom % 2) == 0;
      if (sel < 4) a = m_base;
      else if (sel < 8) a = m_base + 16'd1;
      else if (sel == 8) a = (m_base == 16'h002E) ? 16'h004E : 16'h002E;
      else a = 16'($urandom);
      d = 8'($urandom);
      if (w && a == m_base) begin
        case ($urandom % 8)
          0: d = 8'hAA;
          1, 2: d = 8'h55;
          3: d = 8'h26;
          4: d = 8'h27;
          5: d = 8'h30;
          6: d = 8'h31;
          default: ;
        endcase
      end
      if (w && a == m_base + 16'd1 && m_cfg && m_idx == 8'h27) d = 8'($urandom % 4);
      acc(a, w, !w, d, "R6 R7 random traffic");
    end

    do_reset(1);
    rd(16'h004E, "R5 run read strap-high base");
    wr(16'h002E, 8'h55, "R2 key at low base ignored");
    wr(16'h004E, 8'h55, "R2 unlock strap-high base");
    wr(16'h004E, 8'h26, "R2 index 26");
    rd(16'h004F, "R2 low byte 4E");
    wr(16'h004E, 8'hAA, "R4 lock again");
    finish_run();
  end
endmodule